// File: doc/BRIEF.md
# Array Integrity Signature Engine

This block is a built-in self-test engine for a paged, flash-like array. It reads every page of the blocks it is allowed to touch and folds what it reads into a 32-bit multiple-input signature register. Each page carries 128 data bits, an 8-bit check byte for each 64-bit half, and a single-error flag and a double-error flag for each half.

One run makes five passes over the same sweep of addresses. Each pass feeds a different 32-bit lane of the page into the signature: four data lanes, then a lane that holds the check bytes and error flags. When a pass ends, its signature is stored in one of five result slots. A host reads the slots through an index port. Any user read attempted while the engine is scanning sets a sticky read-while-write error flag.

The array read port is combinational: the engine presents a block and page index, and the page contents come back in the same cycle.

Top module: `integrity_sig_engine`

## Requirements
- R1: After reset, busy, done, rwe_err and rd_en are 0, and every signature slot reads 0.
- R2: A start pulse while idle latches the eligible set, which is blk_sel AND NOT blk_lock AND NOT blk_reserved (bit i is block i). From the next cycle the engine reads one page per cycle. It walks the eligible blocks in ascending block order and pages 0 to PAGES-1 within each block, and it repeats this sweep for five passes, with rd_en high on every read cycle.
- R3: Passes 1 to 4 feed page data bits [31:0], [63:32], [95:64] and [127:96] into the signature, in that order.
- R4: Pass 5 feeds the word {12'b0, rd_dbe[1:0], rd_sbe[1:0], rd_ecc1[7:0], rd_ecc0[7:0]}.
- R5: On each read, the signature becomes {sig[30:0], fb} XOR lane, where fb = sig[31]^sig[21]^sig[1]^sig[0]. The signature starts each pass at zero.
- R6: sig_out shows the stored result of pass sig_idx+1 for sig_idx 0 to 4, and reads 0 for sig_idx 5 to 7. A start while idle clears all slots.
- R7: In the cycle after the last read of pass 5, busy falls and done rises. done stays high until the next start. A start while busy has no effect.
- R8: user_rd sampled while busy sets rwe_err from the next cycle, and rwe_err stays set until the next start. user_rd while idle has no effect.
- R9: If the eligible set is empty at start, the engine reads nothing, done rises in the next cycle, and all slots read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a five-pass run (ignored while busy) |
| blk_sel | input | NUM_BLK | Blocks chosen for the run |
| blk_lock | input | NUM_BLK | Blocks locked against test |
| blk_reserved | input | NUM_BLK | Test and shadow blocks, always excluded |
| user_rd | input | 1 | A user read attempt |
| rd_en | output | 1 | Array read strobe |
| rd_blk | output | BLK_W | Block index of the read |
| rd_page | output | PAGE_W | Page index of the read |
| rd_data | input | 128 | Page data bits |
| rd_ecc0 | input | 8 | Check byte of the lower half |
| rd_ecc1 | input | 8 | Check byte of the upper half |
| rd_sbe | input | 2 | Single-error flags, one per half |
| rd_dbe | input | 2 | Double-error flags, one per half |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Run complete |
| rwe_err | output | 1 | Sticky read-while-write error |
| sig_idx | input | 3 | Result slot select |
| sig_out | output | 32 | Selected result slot |

## Verification
A wrong page or block counter shows up at rd_blk and rd_page in the same cycle it goes wrong, because the bench compares the address against its queue of expected reads on every cycle. A wrong lane, tap or seed shows up in the stored signature at the end of the affected pass. Its effect is visible only through sig_out once done rises, so the bench reads all eight slot indices after every run. A fault in the pass counter changes the cycle in which busy falls, so it shows up within one cycle of the expected end.

// File: rtl/aic_pkg.sv
package aic_pkg;
    localparam int SIG_W    = 32;
    localparam int DATA_W   = 128;
    localparam int ECC_W    = 8;
    localparam int NUM_PASS = 5;
    localparam int PASS_W   = 3;
    localparam int TAP_A    = 31;
    localparam int TAP_B    = 21;
    localparam int TAP_C    = 1;
    localparam int TAP_D    = 0;
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NUM_PASS - 1);
endpackage

// File: rtl/aic_lane_mux.sv
module aic_lane_mux
    import aic_pkg::*;
(
    input  logic [PASS_W-1:0] pass_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ECC_W-1:0]  ecc_lo_i,
    input  logic [ECC_W-1:0]  ecc_hi_i,
    input  logic [1:0]        sbe_i,
    input  logic [1:0]        dbe_i,
    output logic [SIG_W-1:0]  lane_o
);
    localparam int NUM_DATA_LANES = DATA_W / SIG_W;
    localparam int PAD_W = SIG_W - 2*ECC_W - 4;

    logic [SIG_W-1:0] lanes [NUM_PASS];

    for (genvar g = 0; g < NUM_DATA_LANES; g++) begin : g_data_lane
        assign lanes[g] = data_i[g*SIG_W +: SIG_W];
    end

    assign lanes[NUM_PASS-1] = {{PAD_W{1'b0}}, dbe_i, sbe_i, ecc_hi_i, ecc_lo_i};

    always_comb begin
        lane_o = '0;
        if (int'(pass_i) < NUM_PASS) lane_o = lanes[pass_i];
    end
endmodule

// File: rtl/aic_misr_next.sv
module aic_misr_next
    import aic_pkg::*;
(
    input  logic [SIG_W-1:0] cur_i,
    input  logic [SIG_W-1:0] din_i,
    output logic [SIG_W-1:0] nxt_o
);
    logic fb;

    assign fb    = cur_i[TAP_A] ^ cur_i[TAP_B] ^ cur_i[TAP_C] ^ cur_i[TAP_D];
    assign nxt_o = {cur_i[SIG_W-2:0], fb} ^ din_i;
endmodule

// File: rtl/aic_blk_seek.sv
module aic_blk_seek #(
    parameter int NUM_BLK = 4,
    localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic [NUM_BLK-1:0] mask_i,
    input  logic [BLK_W-1:0]   cur_i,
    output logic [BLK_W-1:0]   first_o,
    output logic [BLK_W-1:0]   next_o,
    output logic               any_o,
    output logic               has_next_o
);
    always_comb begin
        first_o    = '0;
        next_o     = '0;
        any_o      = 1'b0;
        has_next_o = 1'b0;
        for (int i = NUM_BLK - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                first_o = BLK_W'(i);
                any_o   = 1'b1;
                if (i > int'(cur_i)) begin
                    next_o     = BLK_W'(i);
                    has_next_o = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/integrity_sig_engine.sv
module integrity_sig_engine
    import aic_pkg::*;
#(
    parameter int NUM_BLK = 4,
    parameter int PAGES   = 8,
    localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
    localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NUM_BLK-1:0] blk_sel,
    input  logic [NUM_BLK-1:0] blk_lock,
    input  logic [NUM_BLK-1:0] blk_reserved,
    input  logic               user_rd,
    output logic               rd_en,
    output logic [BLK_W-1:0]   rd_blk,
    output logic [PAGE_W-1:0]  rd_page,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic [ECC_W-1:0]   rd_ecc0,
    input  logic [ECC_W-1:0]   rd_ecc1,
    input  logic [1:0]         rd_sbe,
    input  logic [1:0]         rd_dbe,
    output logic               busy,
    output logic               done,
    output logic               rwe_err,
    input  logic [2:0]         sig_idx,
    output logic [SIG_W-1:0]   sig_out
);
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGES - 1);

    typedef struct packed {
        logic                             busy;
        logic                             done;
        logic                             rwe;
        logic [PASS_W-1:0]                pass;
        logic [BLK_W-1:0]                 blk;
        logic [PAGE_W-1:0]                page;
        logic [NUM_BLK-1:0]               elig;
        logic [SIG_W-1:0]                 misr;
        logic [NUM_PASS-1:0][SIG_W-1:0]   res;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_BLK-1:0] new_mask, seek_mask;
    logic [BLK_W-1:0]   first_blk, next_blk;
    logic               any_blk, has_next;
    logic [SIG_W-1:0]   lane, misr_nxt;

    assign new_mask  = blk_sel & ~blk_lock & ~blk_reserved;
    assign seek_mask = s_q.busy ? s_q.elig : new_mask;

    aic_blk_seek #(.NUM_BLK(NUM_BLK)) u_seek (
        .mask_i     (seek_mask),
        .cur_i      (s_q.blk),
        .first_o    (first_blk),
        .next_o     (next_blk),
        .any_o      (any_blk),
        .has_next_o (has_next)
    );

    aic_lane_mux u_lane (
        .pass_i   (s_q.pass),
        .data_i   (rd_data),
        .ecc_lo_i (rd_ecc0),
        .ecc_hi_i (rd_ecc1),
        .sbe_i    (rd_sbe),
        .dbe_i    (rd_dbe),
        .lane_o   (lane)
    );

    aic_misr_next u_misr (
        .cur_i (s_q.misr),
        .din_i (lane),
        .nxt_o (misr_nxt)
    );

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (start) begin
                s_d.elig = new_mask;
                s_d.rwe  = 1'b0;
                s_d.busy = any_blk;
                s_d.done = !any_blk;
                s_d.pass = '0;
                s_d.blk  = first_blk;
                s_d.page = '0;
                s_d.misr = '0;
                s_d.res  = '0;
            end
        end else begin
            s_d.misr = misr_nxt;
            if (user_rd) s_d.rwe = 1'b1;
            if (s_q.page == LAST_PAGE) begin
                s_d.page = '0;
                if (has_next) begin
                    s_d.blk = next_blk;
                end else begin
                    s_d.res[s_q.pass] = misr_nxt;
                    s_d.misr          = '0;
                    s_d.blk           = first_blk;
                    if (s_q.pass == LAST_PASS) begin
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.pass = s_q.pass + 1'b1;
                    end
                end
            end else begin
                s_d.page = s_q.page + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_en   = s_q.busy;
    assign rd_blk  = s_q.blk;
    assign rd_page = s_q.page;
    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign rwe_err = s_q.rwe;
    assign sig_out = (int'(sig_idx) < NUM_PASS) ? s_q.res[sig_idx] : '0;

    AST_RD_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> s_q.elig[rd_blk]) else $error("read of ineligible block"); // R2
    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && rd_page != '0) |-> (rd_page == PAGE_W'($past(rd_page) + 1'b1)))
        else $error("page skipped"); // R2
    AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.pass) < NUM_PASS) else $error("pass out of range"); // R2
    AST_MISR_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (s_q.misr == '0)) else $error("signature not seeded"); // R5
    AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done) else $error("done missing at end"); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done while busy"); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(s_q.elig)) else $error("start taken while busy"); // R7
    AST_RWE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && user_rd) |=> rwe_err) else $error("rwe not raised"); // R8
    AST_RWE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rwe_err && !start) |=> rwe_err) else $error("rwe dropped"); // R8
endmodule

// File: tb/integrity_sig_engine_tb.sv
module integrity_sig_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int PG = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NB-1:0] blk_sel = '0, blk_lock = '0, blk_reserved = '0;
    logic          user_rd = 1'b0;
    logic          rd_en;
    logic [1:0]    rd_blk;
    logic [2:0]    rd_page;
    logic [127:0]  rd_data;
    logic [7:0]    rd_ecc0, rd_ecc1;
    logic [1:0]    rd_sbe, rd_dbe;
    logic          busy, done, rwe_err;
    logic [2:0]    sig_idx = '0;
    logic [31:0]   sig_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    integrity_sig_engine #(.NUM_BLK(NB), .PAGES(PG)) dut_i (
        .clk, .rst_n, .start, .blk_sel, .blk_lock, .blk_reserved, .user_rd,
        .rd_en, .rd_blk, .rd_page, .rd_data, .rd_ecc0, .rd_ecc1, .rd_sbe, .rd_dbe,
        .busy, .done, .rwe_err, .sig_idx, .sig_out
    );

    function automatic logic [31:0] mix(int b, int p, int k);
        return (32'(b + 5) * 32'h9E3779B1) ^ (32'(p + 1) * 32'h85EBCA6B) ^ (32'(k + 3) * 32'hC2B2AE35);
    endfunction

    // array model
    always_comb begin
        logic [31:0] ex;
        rd_data = {mix(rd_blk, rd_page, 3), mix(rd_blk, rd_page, 2),
                   mix(rd_blk, rd_page, 1), mix(rd_blk, rd_page, 0)};
        ex      = mix(rd_blk, rd_page, 4);
        rd_ecc0 = ex[7:0];
        rd_ecc1 = ex[15:8];
        rd_sbe  = ex[17:16];
        rd_dbe  = ex[19:18];
    end

    // reference model state
    bit          m_busy, m_done, m_rwe;
    logic [31:0] m_sig [5];
    logic [31:0] m_misr;
    int          q[$];
    int          n_tests = 0, n_fail = 0;
    bit          finished = 0;

    function automatic logic [31:0] model_lane(int pass, int b, int p);
        logic [31:0] ex;
        if (pass < 4) return mix(b, p, pass);
        ex = mix(b, p, 4);
        return {12'h000, ex[19:18], ex[17:16], ex[15:8], ex[7:0]};
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(bit st, bit ur);
        check(busy == m_busy && done == m_done && rwe_err == m_rwe && rd_en == m_busy,
              "R1 R7 R8 R9", "busy/done/rwe/rd_en",
              {busy, done, rwe_err, rd_en}, {m_busy, m_done, m_rwe, m_busy});
        if (m_busy && q.size() > 0)
            check(int'(rd_blk) == (q[0] / 256) % 256 && int'(rd_page) == q[0] % 256,
                  "R2", "read address", {rd_blk, rd_page}, 64'(q[0] % 65536));
        start   = st;
        user_rd = ur;
        if (!m_busy) begin
            if (st) begin
                logic [NB-1:0] el;
                el = blk_sel & ~blk_lock & ~blk_reserved;
                q.delete();
                for (int p = 0; p < 5; p++)
                    for (int b = 0; b < NB; b++)
                        if (el[b])
                            for (int g = 0; g < PG; g++) q.push_back(p * 65536 + b * 256 + g);
                m_rwe = 0;
                m_misr = '0;
                for (int i = 0; i < 5; i++) m_sig[i] = '0;
                m_busy = (q.size() > 0);
                m_done = (q.size() == 0);
            end
        end else begin
            int e, ps;
            logic fb;
            e  = q.pop_front();
            ps = e / 65536;
            fb = ^(m_misr & 32'h8020_0003);
            m_misr = ((m_misr << 1) | 32'(fb)) ^ model_lane(ps, (e / 256) % 256, e % 256);
            if (q.size() == 0 || q[0] / 65536 != ps) begin
                m_sig[ps] = m_misr;
                m_misr = '0;
            end
            if (q.size() == 0) begin
                m_busy = 0;
                m_done = 1;
            end
            if (ur) m_rwe = 1;
        end
        @(negedge clk);
    endtask

    task automatic read_sigs(string req);
        for (int i = 0; i < 8; i++) begin
            sig_idx = 3'(i);
            #1;
            check(sig_out == ((i < 5) ? m_sig[i] : 32'h0), req,
                  $sformatf("slot %0d", i), 64'(sig_out), 64'((i < 5) ? m_sig[i] : 32'h0));
        end
        @(negedge clk);
    endtask

    initial begin
        m_busy = 0; m_done = 0; m_rwe = 0; m_misr = '0;
        for (int i = 0; i < 5; i++) m_sig[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(0, 0);
        tick(0, 0);
        read_sigs("R1 R6");

        // run A: mixed eligibility, user read mid-run, start while busy ignored
        blk_sel = 4'b1111; blk_lock = 4'b0010; blk_reserved = 4'b1000;
        tick(1, 0);
        for (int i = 0; i < 80; i++) tick(i == 7 || i == 40, i == 20); // R7 R8
        tick(0, 0);
        tick(0, 0);
        read_sigs("R3 R4 R5 R6");

        // run B: one block, no user read; idle user reads have no effect
        blk_sel = 4'b0001; blk_lock = 4'b0000; blk_reserved = 4'b0000;
        tick(1, 0);
        while (m_busy) tick(0, 0);
        tick(0, 1);
        tick(0, 1);
        tick(0, 0); // R8: rwe must stay low
        read_sigs("R3 R4 R5 R6");

        // run C: all blocks, user read in the last busy cycle
        blk_sel = 4'b1111;
        tick(1, 0);
        while (m_busy) tick(0, q.size() == 1);
        tick(0, 0);
        read_sigs("R2 R3 R4 R5");

        // run D: empty eligible set
        blk_sel = 4'b0011; blk_lock = 4'b0011;
        tick(1, 0);
        tick(0, 0); // R9
        read_sigs("R9");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule